// File: doc/BRIEF.md
# Noise-Shaping Bitstream Adder

This block sums two single-bit delta-sigma streams into one single-bit stream. The density of ones at the output is half the summed input density. It does not pick one input bit and drop the other, as a multiplexer adder does. Instead it re-modulates the sum: the two input bits and one fed-back state bit enter a 1-bit full adder. The carry becomes the output bit, and the sum bit is held in a delay register for the next sample. The block is therefore a first-order error-feedback modulator. Every input bit reaches the output, and the quantization error of consecutive samples is differenced, which gives first-order noise shaping.

A mode pin selects a second-order error-feedback path instead. In that mode two signed error registers are combined with the current two-bit input sum before a two-level quantizer, so the output noise is shaped to second order. A valid strobe marks the clock cycles that carry a sample. On other cycles the output and all state hold their values. The output is registered, so each result appears one cycle after its inputs.

Top module: `dsm_stream_adder`

## Requirements
- R1: A synchronous reset forces the output bit to 0, clears the full-adder state bit and clears both error registers to 0. The first sample after reset is therefore computed from zero state.
- R2: With the mode pin at 0, each valid sample forms t = x + y + s, where s is the state bit. The output becomes 1 when t is 2 or more, and the new state bit is t modulo 2.
- R3: On cycles with the valid strobe low, the output bit, the state bit and the error registers keep their values whatever the data inputs do. Processing resumes from that held state.
- R4: The output reflects a valid sample right after the rising clock edge that samples it, and not before that edge. The latency is one cycle.
- R5: In first-order mode, over any run of N valid samples starting at reset, (number of input ones on x and y) minus twice (number of output ones) lies in the range 0 to 1.
- R6: In first-order mode, a sample with both inputs at 1 always gives output 1, and a sample with both inputs at 0 always gives output 0.
- R7: With the mode pin at 1, each valid sample forms v = x + y + 2·e1 − e2, where e1 and e2 are the two newest errors as signed integers. The output is 1 when v is at least 1. The new error is v − 2·output, saturated to the signed range of the error width (−32 to 31 by default). It moves into e1 while the old e1 moves into e2.
- R8: In second-order mode, for input densities whose mean lies between 1/8 and 7/8, over a run starting at reset, the magnitude of (input ones) minus twice (output ones) stays at or below 6.
- R9: The mode pin takes effect on the next valid sample. The state of the mode that is not selected holds its value, so switching modes without a reset continues from that held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Marks a cycle that carries one input sample |
| orderSel | input | 1 | 0 selects first-order, 1 selects second-order re-modulation |
| xBit | input | 1 | First input bitstream |
| yBit | input | 1 | Second input bitstream |
| zBit | output | 1 | Registered output bitstream |

## Verification
A wrong state bit or error register is not visible at the output by itself. It shows up as a divergence of the output sequence from the expected recurrence, at the first valid sample in which that state decides the quantizer result. This is usually within a few samples, and always within one sample when the other inputs sit on the decision threshold. The bench therefore compares every output bit against an independent model of the recurrences. It also checks running density error over long pseudo-random streams, so that an error which leaks or drops bits shows up as drift. Held cycles are followed by resumed streams, so that state corrupted while idle is caught at the next samples.

// File: rtl/dsm_adder_pkg.sv
package dsm_adder_pkg;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic advance;    // a sample is consumed this cycle
    logic clear;      // return all state to zero
    logic useSecond;  // second-order path selected
  } dpStrobes_t;

endpackage

// File: rtl/dsm_full_adder.sv
module dsm_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic carry
);

  assign sum   = a ^ b ^ cin;
  assign carry = (a & b) | (a & cin) | (b & cin);

endmodule

// File: rtl/dsm_adder_ctrl.sv
module dsm_adder_ctrl
  import dsm_adder_pkg::*;
#(
  parameter bit ENABLE_SECOND = 1'b1
) (
  input  logic       rst,
  input  logic       validIn,
  input  logic       orderSel,
  output dpStrobes_t strobes
);

  always_comb begin
    strobes.clear     = rst;
    strobes.advance   = validIn & ~rst;
    strobes.useSecond = orderSel & ENABLE_SECOND;
  end

endmodule

// File: rtl/dsm_adder_dp.sv
module dsm_adder_dp
  import dsm_adder_pkg::*;
#(
  parameter int ERR_W         = 6,
  parameter bit ENABLE_SECOND = 1'b1
) (
  input  logic                    clk,
  input  dpStrobes_t              strobes,
  input  logic                    xBit,
  input  logic                    yBit,
  output logic                    zBit,
  output logic                    sumState,
  output logic signed [ERR_W-1:0] err1Q,
  output logic signed [ERR_W-1:0] err2Q
);

  localparam int VW   = ERR_W + 3;
  localparam int EMAX = (1 << (ERR_W - 1)) - 1;
  localparam int EMIN = -(1 << (ERR_W - 1));

  logic faSum;
  logic faCarry;
  logic zSecond;
  logic zQ;
  logic sumQ;

  // first-order path: full adder with its sum bit fed back
  dsm_full_adder u_fa (
    .a     (xBit),
    .b     (yBit),
    .cin   (sumQ),
    .sum   (faSum),
    .carry (faCarry)
  );

  generate
    if (ENABLE_SECOND) begin : g_second
      logic [VW-1:0]        uExt;
      logic signed [VW-1:0] vAcc;
      logic signed [VW-1:0] eRaw;
      logic signed [ERR_W-1:0] errNext;
      logic signed [ERR_W-1:0] e1Q;
      logic signed [ERR_W-1:0] e2Q;

      always_comb begin
        uExt    = VW'(xBit) + VW'(yBit);
        vAcc    = $signed(uExt) + ($signed(VW'(e1Q)) <<< 1) - $signed(VW'(e2Q));
        zSecond = (vAcc > 0);
        eRaw    = zSecond ? (vAcc - VW'(2)) : vAcc;
        if (eRaw > VW'(EMAX)) begin
          errNext = ERR_W'(EMAX);
        end else if (eRaw < VW'(EMIN)) begin
          errNext = ERR_W'(EMIN);
        end else begin
          errNext = eRaw[ERR_W-1:0];
        end
      end

      always_ff @(posedge clk) begin
        if (strobes.clear) begin
          e1Q <= '0;
          e2Q <= '0;
        end else if (strobes.advance && strobes.useSecond) begin
          e1Q <= errNext;
          e2Q <= e1Q;
        end
      end

      assign err1Q = e1Q;
      assign err2Q = e2Q;
    end else begin : g_first_only
      assign zSecond = 1'b0;
      assign err1Q   = '0;
      assign err2Q   = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      zQ   <= 1'b0;
      sumQ <= 1'b0;
    end else if (strobes.advance) begin
      if (strobes.useSecond) begin
        zQ <= zSecond;
      end else begin
        zQ   <= faCarry;
        sumQ <= faSum;
      end
    end
  end

  assign zBit     = zQ;
  assign sumState = sumQ;

endmodule

// File: rtl/dsm_stream_adder.sv
module dsm_stream_adder
  import dsm_adder_pkg::*;
#(
  parameter int ERR_W         = 6,
  parameter bit ENABLE_SECOND = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic validIn,
  input  logic orderSel,
  input  logic xBit,
  input  logic yBit,
  output logic zBit
);

  dpStrobes_t              strobes;
  logic                    sumState;
  logic signed [ERR_W-1:0] err1;
  logic signed [ERR_W-1:0] err2;

  dsm_adder_ctrl #(
    .ENABLE_SECOND (ENABLE_SECOND)
  ) u_ctrl (
    .rst      (rst),
    .validIn  (validIn),
    .orderSel (orderSel),
    .strobes  (strobes)
  );

  dsm_adder_dp #(
    .ERR_W         (ERR_W),
    .ENABLE_SECOND (ENABLE_SECOND)
  ) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .xBit     (xBit),
    .yBit     (yBit),
    .zBit     (zBit),
    .sumState (sumState),
    .err1Q    (err1),
    .err2Q    (err2)
  );

endmodule

// File: rtl/dsm_stream_adder_chk.sv
module dsm_stream_adder_chk #(
  parameter int ERR_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    validIn,
  input logic                    orderSel,
  input logic                    xBit,
  input logic                    yBit,
  input logic                    zBit,
  input logic                    sumState,
  input logic signed [ERR_W-1:0] err1,
  input logic signed [ERR_W-1:0] err2
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!zBit && !sumState && err1 == '0 && err2 == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> ($stable(zBit) && $stable(sumState) && $stable(err1) && $stable(err2)));

  // R2
  majority_out_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && !orderSel) |=>
      (zBit == (($past(xBit) & $past(yBit)) | ($past(xBit) & $past(sumState)) |
                ($past(yBit) & $past(sumState)))));

  // R6
  both_high_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && !orderSel && xBit && yBit) |=> zBit);

  // R6
  both_low_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && !orderSel && !xBit && !yBit) |=> !zBit);

  // R7
  second_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && orderSel && err1 == '0 && err2 == '0 && (xBit || yBit)) |=> zBit);

  // R9
  first_keeps_err_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && !orderSel) |=> ($stable(err1) && $stable(err2)));

endmodule

bind dsm_stream_adder dsm_stream_adder_chk #(.ERR_W(ERR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .orderSel (orderSel),
  .xBit     (xBit),
  .yBit     (yBit),
  .zBit     (zBit),
  .sumState (sumState),
  .err1     (err1),
  .err2     (err2)
);

// File: tb/sim_dsm_stream_adder.sv
`timescale 1ns/1ps
module sim_dsm_stream_adder;

  localparam int ERR_W = 6;
  localparam int EMAX  = (1 << (ERR_W - 1)) - 1;
  localparam int EMIN  = -(1 << (ERR_W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic orderSel = 1'b0;
  logic xBit = 1'b0;
  logic yBit = 1'b0;
  logic zBit;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // reference state, built from the requirement text
  int mS, mE1, mE2, expZ;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  dsm_stream_adder #(.ERR_W(ERR_W)) u0 (
    .clk(clk), .rst(rst), .validIn(validIn), .orderSel(orderSel),
    .xBit(xBit), .yBit(yBit), .zBit(zBit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  task automatic modelAdvance(input logic x, input logic y);
    int t, v, e;
    if (!orderSel) begin
      t    = int'(x) + int'(y) + mS;
      expZ = (t >= 2) ? 1 : 0;
      mS   = t % 2;
    end else begin
      v    = int'(x) + int'(y) + 2 * mE1 - mE2;
      expZ = (v >= 1) ? 1 : 0;
      e    = v - 2 * expZ;
      if (e > EMAX) e = EMAX;
      if (e < EMIN) e = EMIN;
      mE2  = mE1;
      mE1  = e;
    end
  endtask

  task automatic step(input logic v, input logic x, input logic y, input string tag);
    validIn = v;
    xBit    = x;
    yBit    = y;
    if (v) modelAdvance(x, y);
    @(negedge clk);
    check(zBit == expZ[0], tag, int'(zBit), expZ);
  endtask

  task automatic doReset();
    rst = 1'b1;
    validIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(zBit == 1'b0, "R1 output after reset", int'(zBit), 0);
    rst = 1'b0;
    mS = 0; mE1 = 0; mE2 = 0; expZ = 0;
  endtask

  task automatic runPattern(input int dx, input int dy, input int n, input string tag,
                            output int sumU, output int sumZ);
    logic x, y;
    sumU = 0;
    sumZ = 0;
    for (int i = 0; i < n; i++) begin
      lfsr = nextLfsr(lfsr);
      x = (int'(lfsr[7:0]) < dx);
      y = (int'(lfsr[15:8]) < dy);
      step(1'b1, x, y, tag);
      sumU += int'(x) + int'(y);
      sumZ += int'(zBit);
    end
  endtask

  // R1: state built up before reset must not survive it
  task automatic testReset();
    orderSel = 1'b0;
    doReset();
    step(1'b1, 1'b1, 1'b0, "R1 first sample");
    doReset();
    step(1'b1, 1'b1, 1'b0, "R1 state cleared by reset");
    step(1'b1, 1'b1, 1'b0, "R1 second sample");
  endtask

  // R4: no change before the sampling edge, change right after it
  task automatic testLatency();
    orderSel = 1'b0;
    doReset();
    validIn = 1'b1; xBit = 1'b1; yBit = 1'b1;
    modelAdvance(1'b1, 1'b1);
    #1;
    check(zBit == 1'b0, "R4 before edge", int'(zBit), 0);
    @(negedge clk);
    check(zBit == 1'b1, "R4 after edge", int'(zBit), 1);
    validIn = 1'b0;
  endtask

  // R2 and R5 under several density pairs
  task automatic testFirstOrder();
    int dxs[4] = '{64, 128, 20, 200};
    int dys[4] = '{192, 128, 240, 90};
    int su, sz;
    orderSel = 1'b0;
    for (int p = 0; p < 4; p++) begin
      doReset();
      runPattern(dxs[p], dys[p], 120, "R2 bit match", su, sz);
      check((su - 2 * sz) >= 0 && (su - 2 * sz) <= 1, "R5 density error", su - 2 * sz, 0);
    end
  endtask

  // R3: idle cycles with moving data, then resume
  task automatic testHold();
    int su, sz;
    orderSel = 1'b0;
    doReset();
    runPattern(100, 170, 11, "R3 lead-in", su, sz);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, i[0], ~i[1], "R3 idle hold");
    end
    runPattern(100, 170, 24, "R3 resume", su, sz);
    orderSel = 1'b1;
    doReset();
    runPattern(90, 150, 9, "R3 lead-in second", su, sz);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, ~i[0], i[0], "R3 idle hold second");
    end
    runPattern(90, 150, 24, "R3 resume second", su, sz);
  endtask

  // R6: saturated input patterns
  task automatic testExtremes();
    orderSel = 1'b0;
    doReset();
    step(1'b1, 1'b1, 1'b0, "R6 preset state");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b1, "R6 both high");
      check(zBit == 1'b1, "R6 both high gives one", int'(zBit), 1);
    end
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, 1'b0, "R6 both low");
      check(zBit == 1'b0, "R6 both low gives zero", int'(zBit), 0);
    end
  endtask

  // R7, R8, R9
  task automatic testSecondOrder();
    int dxs[4] = '{128, 60, 220, 170};
    int dys[4] = '{128, 100, 180, 30};
    int su, sz, d;
    orderSel = 1'b1;
    for (int p = 0; p < 4; p++) begin
      doReset();
      runPattern(dxs[p], dys[p], 160, "R7 bit match", su, sz);
      d = su - 2 * sz;
      check(d <= 6 && d >= -6, "R8 density error", d, 0);
    end
    // mode switch without reset: held state of each mode is reused
    orderSel = 1'b0;
    doReset();
    runPattern(150, 60, 7, "R9 first before switch", su, sz);
    orderSel = 1'b1;
    runPattern(150, 60, 13, "R9 second after switch", su, sz);
    orderSel = 1'b0;
    runPattern(150, 60, 13, "R9 first resumed", su, sz);
    orderSel = 1'b1;
    runPattern(150, 60, 13, "R9 second resumed", su, sz);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testLatency();
    testFirstOrder();
    testHold();
    testExtremes();
    testSecondOrder();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule